// File: doc/BRIEF.md
# Traffic Test Control and Status Registers

This block is a word-addressed register file that sits between a management bus and a set of packet traffic generators and checkers. Software uses it to start the fronthaul traffic (control plane, control-plane extension and user plane) and the timing/miscellaneous traffic, to choose continuous mode, and to clear error counts. It also carries a line-rate change request to a separate agent: software sets the request bit and polls it, and the bit drops only when that agent reports completion.

Apart from the control words, the block shows a read-only word that reflects the system build options. It also keeps two banks of event counters: one for the external traffic and one for the fronthaul traffic. The traffic logic feeds each counter a one-cycle event strobe. Counters that a mask parameter marks as error counters are zeroed by the clear-error pulse. The other counters are not touched by that pulse.

Every access is one cycle long. A read returns its data, with a valid flag, on the cycle after the request. A write lands on the clock edge where it is presented.

Top module: `traffic_csr`

## Requirements
- R1: After synchronous reset, words 0, 1, 2 and 4 read 0 and every counter reads 0. Word 3 reads 0x80 when TILE_E=1 (the default) and 0x00 when TILE_E=0. `rvalid`, `clr_err` and `rate_req` are low.
- R2: A read request with `rd_en` high at clock edge t gives `rvalid`=1 and the addressed word on `rdata` after edge t. `rvalid` is low after any edge where `rd_en` was low.
- R3: Word 0 is read/write. Bit 0 drives `start_fh` and bit 1 drives `start_sync`. The other bits read 0.
- R4: Word 1 bit 0 is read/write and drives `cont_en`. The other bits read 0.
- R5: Writing word 2 with bit 0 set makes `clr_err` high for exactly the one cycle after that write's edge. Word 2 always reads 0.
- R6: Writing word 3 loads bit 7 into `rate_tile` and bits 6:4 into `rate_dir` (0 = faster-to-slower, 1 = slower-to-faster). Writing bit 0 as 1 sets `rate_req`. Writing bit 0 as 0 leaves `rate_req` unchanged. Word 3 reads {tile, dir, 3'b0, req}.
- R7: While `rate_req` is high, a high `rate_done_in` clears it at that edge and sets the done flag in word 4 bit 1. A later write that sets the request clears the flag again.
- R8: Word 5 is read-only and reads: bit 31 `cfg_ready`, bits 12:5 `cfg_comp_param`, bit 4 `cfg_comp_en`, bit 3 `cfg_ext_en`, bit 2 `cfg_cpext_en`, bit 1 `cfg_cp_en`, bit 0 `cfg_up_en`. All other bits read 0.
- R9: Words 0x22 to 0x22+NUM_EXT-1 read external counter i = word-0x22. Words 0x60 to 0x60+NUM_FH-1 read fronthaul counter i = word-0x60. Each counter goes up by one at every edge where its event bit is high.
- R10: `clr_err` zeroes exactly the counters whose bit is set in EXT_ERR_MASK or FH_ERR_MASK, and the clear wins over an event in the same cycle. By default these are word 0x28 and words 0x64, 0x65, 0x70, 0x73 and 0x76. The other counters keep their values.
- R11: Writes to words 4 and 5, to counter words and to reserved words change nothing. Reserved words read 0.
- R12: A high `rate_done_in` while `rate_req` is low changes neither word 3 nor word 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (8) | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| start_fh | output | 1 | Start fronthaul traffic |
| start_sync | output | 1 | Start timing/miscellaneous traffic |
| cont_en | output | 1 | Continuous traffic mode |
| clr_err | output | 1 | One-cycle error clear pulse |
| rate_req | output | 1 | Line-rate change request |
| rate_dir | output | 3 | Rate change direction code |
| rate_tile | output | 1 | Transceiver variant select |
| rate_done_in | input | 1 | Rate change completion from the agent |
| cfg_ready | input | 1 | System ready |
| cfg_comp_param | input | 8 | Compression parameter |
| cfg_comp_en | input | 1 | Compression enabled |
| cfg_ext_en | input | 1 | External packets enabled |
| cfg_cpext_en | input | 1 | Control-plane extension enabled |
| cfg_cp_en | input | 1 | Control plane enabled |
| cfg_up_en | input | 1 | User plane enabled |
| ext_evt | input | NUM_EXT (7) | External counter event strobes |
| fh_evt | input | NUM_FH (23) | Fronthaul counter event strobes |

## Verification
The hardest states to reach from the ports are the rate handshake corners and the selective clear. Two of these are a completion that arrives with no request pending, and a write to word 3 with bit 0 at 0 while a request is open. The stimulus first opens a request, then rewrites the word with only the tile bit set, and then pulses the completion input twice. Word 3 and word 4 are read after each step. For the clear, every counter is first made non-zero with event strobes, and one external counter is pulsed twice. After that, the whole bank is read back to confirm that only the masked words went to zero.

// File: rtl/traffic_csr_pkg.sv
// Shared word offsets and types for the traffic control/status registers.
// Assumes word addressing and a 32-bit data bus.
package traffic_csr_pkg;
    localparam int DATA_W    = 32;
    localparam int WD_START  = 0;
    localparam int WD_CONT   = 1;
    localparam int WD_CLR    = 2;
    localparam int WD_RATE   = 3;
    localparam int WD_RDONE  = 4;
    localparam int WD_SYSCFG = 5;
    localparam int EXT_BASE  = 'h22;
    localparam int FH_BASE   = 'h60;

    typedef logic [DATA_W-1:0] word_t;

    // Rate change request fields as held in word 3
    typedef struct packed {
        logic       tile;
        logic [2:0] dir;
        logic       req;
    } rate_cfg_t;
endpackage

// File: rtl/tcsr_ctrl_regs.sv
// Writable control words: start bits, continuous mode, clear strobe and
// the rate change request with its completion handshake.
// Assumes one write per cycle; the write takes effect on the edge it is seen.
module tcsr_ctrl_regs
    import traffic_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter bit TILE_E = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    input  logic              rate_done_in,
    output logic              start_fh,
    output logic              start_sync,
    output logic              cont_en,
    output logic              clr_err,
    output rate_cfg_t         rate_cfg,
    output logic              rate_done_flag
);
    logic hit_start, hit_cont, hit_clr, hit_rate;
    logic set_req;

    // Decode the word that the write strobe targets
    always_comb begin
        hit_start = wr_en && (addr == ADDR_W'(WD_START));
        hit_cont  = wr_en && (addr == ADDR_W'(WD_CONT));
        hit_clr   = wr_en && (addr == ADDR_W'(WD_CLR));
        hit_rate  = wr_en && (addr == ADDR_W'(WD_RATE));
        set_req   = hit_rate && wdata[0];
    end

    // Start bits and continuous mode hold the last value written
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_fh   <= 1'b0;
            start_sync <= 1'b0;
            cont_en    <= 1'b0;
        end else begin
            if (hit_start) begin
                start_fh   <= wdata[0];
                start_sync <= wdata[1];
            end
            if (hit_cont) cont_en <= wdata[0];
        end
    end

    // Clear strobe: one cycle high after a write of 1 to the clear word
    always_ff @(posedge clk) begin
        if (!rst_n) clr_err <= 1'b0;
        else        clr_err <= hit_clr && wdata[0];
    end

    // Rate request: software sets it, only a completion clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_cfg       <= '{tile: TILE_E, dir: 3'd0, req: 1'b0};
            rate_done_flag <= 1'b0;
        end else begin
            if (hit_rate) begin
                rate_cfg.tile <= wdata[7];
                rate_cfg.dir  <= wdata[6:4];
            end
            if (set_req) begin
                rate_cfg.req   <= 1'b1;
                rate_done_flag <= 1'b0;
            end else if (rate_cfg.req && rate_done_in) begin
                rate_cfg.req   <= 1'b0;
                rate_done_flag <= 1'b1;
            end
        end
    end

    // R5: a clear pulse only follows a write of 1 to the clear word
    p_clr_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |-> $past(wr_en && addr == ADDR_W'(WD_CLR) && wdata[0]));
    // R7: the request drops only on a completion
    p_req_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rate_cfg.req) |-> $past(rate_done_in));
    // R7: the done flag rises only when a request was open
    p_flag_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rate_done_flag) |-> $past(rate_cfg.req));
    // R6: an open request with no completion stays open
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rate_cfg.req) && !$past(rate_done_in)) |-> rate_cfg.req);
endmodule

// File: rtl/tcsr_cnt_bank.sv
// A bank of event counters. Each lane counts its one-cycle strobe; the
// lanes flagged in ERR_MASK are zeroed by the clear pulse, which wins over
// an event in the same cycle. Counters wrap at their width.
module tcsr_cnt_bank #(
    parameter int            NUM      = 7,
    parameter int            CNT_W    = 32,
    parameter logic [NUM-1:0] ERR_MASK = '0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic [NUM-1:0]            evt,
    output logic [NUM-1:0][CNT_W-1:0] cnt
);
    for (genvar i = 0; i < NUM; i++) begin : g_lane
        if (ERR_MASK[i]) begin : g_err
            // Error lane: counts events, zeroed by the clear pulse
            always_ff @(posedge clk) begin
                if (!rst_n || clr) cnt[i] <= '0;
                else if (evt[i])   cnt[i] <= cnt[i] + CNT_W'(1);
            end
            // R10: an error lane reads zero right after a clear
            p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
                $past(clr) |-> cnt[i] == '0);
        end else begin : g_plain
            // Plain lane: counts events, never cleared outside reset
            always_ff @(posedge clk) begin
                if (!rst_n)      cnt[i] <= '0;
                else if (evt[i]) cnt[i] <= cnt[i] + CNT_W'(1);
            end
            // R10: a plain lane is not disturbed by the clear pulse
            p_plain_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(clr) && !$past(evt[i])) |-> $stable(cnt[i]));
        end
        // R9: a lane moves by exactly its event, or is cleared
        p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(clr) |-> cnt[i] == $past(cnt[i]) + CNT_W'($past(evt[i])));
    end
endmodule

// File: rtl/traffic_csr.sv
// Top of the traffic control/status register block. It joins the control
// words, the two counter banks and a registered read mux. Reads return one
// cycle after rd_en. Writes to read-only or reserved words are dropped.
// Assumes CNT_W <= 32 and that both banks fit below 2**ADDR_W.
module traffic_csr
    import traffic_csr_pkg::*;
#(
    parameter int ADDR_W                  = 8,
    parameter int NUM_EXT                 = 7,
    parameter int NUM_FH                  = 23,
    parameter int CNT_W                   = 32,
    parameter bit TILE_E                  = 1'b1,
    parameter logic [NUM_EXT-1:0] EXT_ERR_MASK = 7'h40,
    parameter logic [NUM_FH-1:0]  FH_ERR_MASK  = 23'h490030
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    output logic               rvalid,
    output logic               start_fh,
    output logic               start_sync,
    output logic               cont_en,
    output logic               clr_err,
    output logic               rate_req,
    output logic [2:0]         rate_dir,
    output logic               rate_tile,
    input  logic               rate_done_in,
    input  logic               cfg_ready,
    input  logic [7:0]         cfg_comp_param,
    input  logic               cfg_comp_en,
    input  logic               cfg_ext_en,
    input  logic               cfg_cpext_en,
    input  logic               cfg_cp_en,
    input  logic               cfg_up_en,
    input  logic [NUM_EXT-1:0] ext_evt,
    input  logic [NUM_FH-1:0]  fh_evt
);
    localparam int EXT_IW = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1;
    localparam int FH_IW  = (NUM_FH > 1) ? $clog2(NUM_FH) : 1;

    rate_cfg_t                        rate_cfg;
    logic                             rate_done_flag;
    logic [NUM_EXT-1:0][CNT_W-1:0]    ext_cnt;
    logic [NUM_FH-1:0][CNT_W-1:0]     fh_cnt;
    logic [ADDR_W-1:0]                ext_off, fh_off;
    word_t                            rd_mux;

    tcsr_ctrl_regs #(.ADDR_W(ADDR_W), .TILE_E(TILE_E)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en          (wr_en),
        .addr           (addr),
        .wdata          (wdata),
        .rate_done_in   (rate_done_in),
        .start_fh       (start_fh),
        .start_sync     (start_sync),
        .cont_en        (cont_en),
        .clr_err        (clr_err),
        .rate_cfg       (rate_cfg),
        .rate_done_flag (rate_done_flag)
    );

    tcsr_cnt_bank #(.NUM(NUM_EXT), .CNT_W(CNT_W), .ERR_MASK(EXT_ERR_MASK)) u_ext_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_err),
        .evt   (ext_evt),
        .cnt   (ext_cnt)
    );

    tcsr_cnt_bank #(.NUM(NUM_FH), .CNT_W(CNT_W), .ERR_MASK(FH_ERR_MASK)) u_fh_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_err),
        .evt   (fh_evt),
        .cnt   (fh_cnt)
    );

    assign rate_req  = rate_cfg.req;
    assign rate_dir  = rate_cfg.dir;
    assign rate_tile = rate_cfg.tile;

    // Select the addressed word; reserved words give zero
    always_comb begin
        ext_off = addr - ADDR_W'(EXT_BASE);
        fh_off  = addr - ADDR_W'(FH_BASE);
        rd_mux  = '0;
        if (addr == ADDR_W'(WD_START))
            rd_mux = {30'd0, start_sync, start_fh};
        else if (addr == ADDR_W'(WD_CONT))
            rd_mux = {31'd0, cont_en};
        else if (addr == ADDR_W'(WD_RATE))
            rd_mux = {24'd0, rate_cfg.tile, rate_cfg.dir, 3'd0, rate_cfg.req};
        else if (addr == ADDR_W'(WD_RDONE))
            rd_mux = {30'd0, rate_done_flag, 1'b0};
        else if (addr == ADDR_W'(WD_SYSCFG))
            rd_mux = {cfg_ready, 18'd0, cfg_comp_param, cfg_comp_en, cfg_ext_en,
                      cfg_cpext_en, cfg_cp_en, cfg_up_en};
        else if (addr >= ADDR_W'(EXT_BASE) && addr < ADDR_W'(EXT_BASE + NUM_EXT))
            rd_mux = 32'(ext_cnt[ext_off[EXT_IW-1:0]]);
        else if (addr >= ADDR_W'(FH_BASE) && addr < ADDR_W'(FH_BASE + NUM_FH))
            rd_mux = 32'(fh_cnt[fh_off[FH_IW-1:0]]);
    end

    // Register the read data one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= rd_en;
            rdata  <= rd_en ? rd_mux : '0;
        end
    end

    // R2: valid data only follows a read request
    p_rvalid_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en));
    // R2: a read request always yields valid data next cycle
    p_rvalid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    // R5: the clear word never reads back as non-zero
    p_clr_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && $past(addr) == ADDR_W'(WD_CLR)) |-> rdata == '0);
    // R11: a reserved word reads zero
    p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && $past(addr) > ADDR_W'(WD_SYSCFG) && $past(addr) < ADDR_W'(EXT_BASE))
        |-> rdata == '0);
endmodule

// File: tb/traffic_csr_tb.sv
// Self-checking bench: a vector table of register accesses, then directed
// tests of the rate handshake, counters and selective clear.
module traffic_csr_tb;
    localparam int NUM_EXT = 7;
    localparam int NUM_FH  = 23;
    localparam logic [NUM_EXT-1:0] EXT_MASK = 7'h40;
    localparam logic [NUM_FH-1:0]  FH_MASK  = 23'h490030;
    localparam logic [31:0] SYSCFG_EXP = 32'h800014B6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic rvalid, start_fh, start_sync, cont_en, clr_err, rate_req, rate_tile;
    logic [2:0] rate_dir;
    logic rate_done_in = 1'b0;
    logic [NUM_EXT-1:0] ext_evt = '0;
    logic [NUM_FH-1:0]  fh_evt = '0;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    traffic_csr u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .start_fh(start_fh),
        .start_sync(start_sync), .cont_en(cont_en), .clr_err(clr_err),
        .rate_req(rate_req), .rate_dir(rate_dir), .rate_tile(rate_tile),
        .rate_done_in(rate_done_in), .cfg_ready(1'b1), .cfg_comp_param(8'hA5),
        .cfg_comp_en(1'b1), .cfg_ext_en(1'b0), .cfg_cpext_en(1'b1),
        .cfg_cp_en(1'b1), .cfg_up_en(1'b0), .ext_evt(ext_evt), .fh_evt(fh_evt)
    );

    // Entry: {is_read, req number, word, write data, expected read}
    localparam int NV = 23;
    localparam logic [76:0] VEC [NV] = '{
        {1'b1, 4'd1,  8'h03, 32'h0,        32'h80},       // R1 rate word reset
        {1'b1, 4'd1,  8'h00, 32'h0,        32'h0},        // R1
        {1'b1, 4'd1,  8'h01, 32'h0,        32'h0},        // R1
        {1'b0, 4'd3,  8'h00, 32'h3,        32'h0},        // R3 both starts
        {1'b1, 4'd3,  8'h00, 32'h0,        32'h3},
        {1'b0, 4'd3,  8'h00, 32'hFFFFFFFE, 32'h0},        // R3 upper bits dropped
        {1'b1, 4'd3,  8'h00, 32'h0,        32'h2},
        {1'b0, 4'd4,  8'h01, 32'hFFFFFFFF, 32'h0},        // R4
        {1'b1, 4'd4,  8'h01, 32'h0,        32'h1},
        {1'b1, 4'd5,  8'h02, 32'h0,        32'h0},        // R5 reads zero
        {1'b1, 4'd8,  8'h05, 32'h0,        SYSCFG_EXP},   // R8 layout
        {1'b0, 4'd11, 8'h05, 32'h0,        32'h0},        // R11 RO write
        {1'b1, 4'd11, 8'h05, 32'h0,        SYSCFG_EXP},
        {1'b1, 4'd11, 8'h06, 32'h0,        32'h0},        // R11 reserved
        {1'b0, 4'd11, 8'h30, 32'h1234,     32'h0},
        {1'b1, 4'd11, 8'h30, 32'h0,        32'h0},
        {1'b0, 4'd11, 8'h22, 32'h55,       32'h0},        // R11 counter write
        {1'b1, 4'd11, 8'h22, 32'h0,        32'h0},
        {1'b0, 4'd6,  8'h03, 32'h31,       32'h0},        // R6 dir 3, request
        {1'b1, 4'd6,  8'h03, 32'h0,        32'h31},
        {1'b1, 4'd7,  8'h04, 32'h0,        32'h0},        // R7 not done yet
        {1'b0, 4'd6,  8'h03, 32'h80,       32'h0},        // R6 bit0=0 keeps req
        {1'b1, 4'd6,  8'h03, 32'h0,        32'h81}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check(req, {31'd0, rvalid}, 32'd1);
        check(req, rdata, exp);
    endtask

    task automatic pulse_done;
        @(negedge clk); rate_done_in = 1'b1;
        @(negedge clk); rate_done_in = 1'b0;
    endtask

    task automatic pulse_evt(input logic [NUM_EXT-1:0] e, input logic [NUM_FH-1:0] f);
        @(negedge clk); ext_evt = e; fh_evt = f;
        @(negedge clk); ext_evt = '0; fh_evt = '0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check("R1 rvalid", {31'd0, rvalid}, 32'd0);
        check("R1 clr_err", {31'd0, clr_err}, 32'd0);
        check("R1 rate_req", {31'd0, rate_req}, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76])
                rd_check($sformatf("R%0d vec%0d", VEC[i][75:72], i), VEC[i][71:64], VEC[i][31:0]);
            else
                wr(VEC[i][71:64], VEC[i][63:32]);
        end

        // R3/R4/R6: levels at the ports
        check("R3 start_fh", {31'd0, start_fh}, 32'd0);
        check("R3 start_sync", {31'd0, start_sync}, 32'd1);
        check("R4 cont_en", {31'd0, cont_en}, 32'd1);
        check("R6 rate_req", {31'd0, rate_req}, 32'd1);
        check("R6 rate_tile", {31'd0, rate_tile}, 32'd1);
        check("R6 rate_dir", {29'd0, rate_dir}, 32'd0);

        // R7: completion closes the request and raises the done flag
        pulse_done();
        check("R7 rate_req", {31'd0, rate_req}, 32'd0);
        rd_check("R7 word3", 8'h03, 32'h80);
        rd_check("R7 word4", 8'h04, 32'h2);
        // R12: stray completion has no effect
        pulse_done();
        rd_check("R12 word3", 8'h03, 32'h80);
        rd_check("R12 word4", 8'h04, 32'h2);
        // R7: a new request clears the done flag
        wr(8'h03, 32'h11);
        rd_check("R7 new req word3", 8'h03, 32'h11);
        rd_check("R7 flag cleared", 8'h04, 32'h0);
        wr(8'h04, 32'h2);  // R11: RO write to done word
        rd_check("R11 word4", 8'h04, 32'h0);

        // R9: each counter counts its strobe
        pulse_evt('1, '1);
        pulse_evt(7'h01, '0);
        rd_check("R9 ext0", 8'h22, 32'd2);
        for (int i = 1; i < NUM_EXT; i++)
            rd_check($sformatf("R9 ext%0d", i), 8'(8'h22 + i), 32'd1);
        for (int i = 0; i < NUM_FH; i++)
            rd_check($sformatf("R9 fh%0d", i), 8'(8'h60 + i), 32'd1);

        // R5: clear pulse lasts exactly one cycle
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h02; wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        check("R5 clr high", {31'd0, clr_err}, 32'd1);
        @(negedge clk);
        check("R5 clr low", {31'd0, clr_err}, 32'd0);

        // R10: only masked counters cleared
        for (int i = 0; i < NUM_EXT; i++)
            rd_check($sformatf("R10 ext%0d", i), 8'(8'h22 + i),
                     EXT_MASK[i] ? 32'd0 : ((i == 0) ? 32'd2 : 32'd1));
        for (int i = 0; i < NUM_FH; i++)
            rd_check($sformatf("R10 fh%0d", i), 8'(8'h60 + i), FH_MASK[i] ? 32'd0 : 32'd1);

        // R10: clear wins over a same-cycle event
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h02; wdata = 32'h1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0; ext_evt = 7'h40;
        @(negedge clk);
        ext_evt = '0;
        rd_check("R10 clear wins", 8'h28, 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule